// File: doc/BRIEF.md
# Warm Reset Handshake Sequencer

This block runs a warm reset as a hardware-controlled sequence. A one-cycle software pulse or an external warm-reset request starts it from idle. Before warm reset is driven, the sequencer works through five targets, one at a time. For each target it can raise a request and hold it until that target acknowledges. The targets are: SDRAM self-refresh entry, so memory contents survive; configuration-manager clock parking; scan-manager clock parking; fabric notification; and the trace bus master stall, which drains outstanding AXI traffic.

A target is visited only when its enable bit is set and it is not already held in warm reset. Every wait is bounded by a programmable cycle limit. A wait that runs out leaves a sticky per-target timeout flag and the sequence carries on. When warm reset is released, the four ordinary requests drop. The trace stall stays asserted behind a pending flag until software clears it. A cold-reset pulse aborts whatever is in progress.

Top module: `warm_rst_seq`

## Requirements
- R1: After `rst`, `hs_req_o`, `warm_rst_o`, `stall_pend_o`, `hs_timeout_o` and `busy_o` are all 0.
- R2: A pulse on `sw_warm_req_i` or `ext_warm_req_i` while idle sets `busy_o` on the next cycle. A pulse while busy has no effect: no second warm reset follows.
- R3: Target bit order in every per-target vector is fixed: bit 0 SDRAM, 1 configuration manager, 2 scan manager, 3 fabric, 4 trace master. Targets are visited in ascending bit order, at most one request rises per cycle, and a target whose `hs_en_i` bit is 0 never gets a request.
- R4: A target whose `tgt_in_rst_i` bit is 1 is skipped even when enabled.
- R5: A request, once raised, stays high until the end of warm reset. An acknowledge moves the sequence on to the next target in the following cycle.
- R6: If no acknowledge arrives within `timeout_cyc_i`+1 wait cycles, that target's `hs_timeout_o` bit is set and the sequence proceeds. All timeout bits are cleared when a new sequence starts.
- R7: `warm_rst_o` rises only after every visited target has finished. It stays high for `rst_len_i` cycles, or for 1 cycle when `rst_len_i` is 0, and is never high while idle.
- R8: When `warm_rst_o` falls, request bits 3..0 are 0.
- R9: If `hs_en_i[4]` is 1 when warm reset ends, `stall_pend_o` and `hs_req_o[4]` go to 1. Both stay at 1 until `stall_clr_i` is seen while idle, and `hs_req_o[4]` is 1 whenever `stall_pend_o` is 1.
- R10: A pulse on `cold_req_i` returns the sequencer to idle on the next cycle, with all requests, flags and warm reset cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cold_req_i | input | 1 | Cold-reset pulse; aborts any sequence |
| sw_warm_req_i | input | 1 | Software warm-reset pulse |
| ext_warm_req_i | input | 1 | External warm-reset request pulse |
| hs_en_i | input | 5 | Per-target handshake enable |
| tgt_in_rst_i | input | 5 | Per-target "already in warm reset" |
| hs_ack_i | input | 5 | Per-target acknowledge |
| timeout_cyc_i | input | TO_W | Handshake wait limit |
| rst_len_i | input | LEN_W | Warm reset length in cycles |
| stall_clr_i | input | 1 | Clears the trace-stall pending flag |
| hs_req_o | output | 5 | Per-target request |
| warm_rst_o | output | 1 | Warm reset output |
| stall_pend_o | output | 1 | Trace stall pending after reset |
| hs_timeout_o | output | 5 | Sticky per-target timeout flags |
| busy_o | output | 1 | Sequence in progress |

## Verification
Some properties are checked on every cycle:
- at most one request rises at a time, and never for a disabled or already-reset target;
- no request rises while warm reset is driven;
- the ordinary requests are down when warm reset falls;
- the pending flag implies the trace stall;
- cold abort and start from idle.

Other behaviour is left to the bench's scenarios and its cycle-exact reference model:
- the ascending order of visits;
- the exact timeout cycle and the clearing of stale timeout flags;
- the warm reset length, including length 0;
- that a trigger while busy yields no second reset.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    localparam int N_TGT     = 5;
    localparam int IDX_W     = 3;
    localparam int TGT_SDRAM = 0;
    localparam int TGT_CFG   = 1;
    localparam int TGT_SCAN  = 2;
    localparam int TGT_FAB   = 3;
    localparam int TGT_TRACE = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_ASSERT
    } wrs_state_e;

    typedef struct packed {
        logic             start;
        logic             cnt_clr;
        logic             cnt_inc;
        logic [N_TGT-1:0] grant;
        logic [N_TGT-1:0] tout;
        logic             rst_end;
    } wrs_ctl_t;

    function automatic logic [N_TGT-1:0] idx_onehot(input logic [IDX_W-1:0] i);
        logic [N_TGT-1:0] v;
        v = '0;
        for (int b = 0; b < N_TGT; b++) begin
            if (i == IDX_W'(b)) v[b] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic pick(input logic [N_TGT-1:0] vec, input logic [IDX_W-1:0] i);
        return |(vec & idx_onehot(i));
    endfunction

    function automatic logic step_on(input logic [N_TGT-1:0] en,
                                     input logic [N_TGT-1:0] inrst,
                                     input logic [IDX_W-1:0] i);
        return pick(en & ~inrst, i);
    endfunction

endpackage

// File: rtl/wrs_counter.sv
module wrs_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cold,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || cold || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wrs_fsm.sv
module wrs_fsm
    import wrs_pkg::*;
#(
    parameter int TO_W  = 8,
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cold,
    input  logic             trig,
    input  logic [N_TGT-1:0] en,
    input  logic [N_TGT-1:0] inrst,
    input  logic [N_TGT-1:0] ack,
    input  logic [CNT_W-1:0] cnt,
    input  logic [TO_W-1:0]  timeout,
    input  logic [LEN_W-1:0] rst_len,
    output wrs_state_e       state,
    output wrs_ctl_t         ctl
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TGT_TRACE);

    wrs_state_e       state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [CNT_W-1:0] len_eff;
    logic             len_done;
    logic             hit;
    logic             expire;

    always_comb begin
        len_eff  = (rst_len == '0) ? CNT_W'(1) : CNT_W'(rst_len);
        len_done = ((CNT_W+1)'(cnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(len_eff);
        hit      = pick(ack, idx);
        expire   = (cnt == CNT_W'(timeout));
    end

    always_comb begin
        ctl     = '0;
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_IDLE: begin
                if (trig) begin
                    ctl.start = 1'b1;
                    state_n   = ST_CHECK;
                    idx_n     = '0;
                end
            end
            ST_CHECK: begin
                if (step_on(en, inrst, idx)) begin
                    ctl.grant   = idx_onehot(idx);
                    ctl.cnt_clr = 1'b1;
                    state_n     = ST_WAIT;
                end else if (idx == LAST) begin
                    ctl.cnt_clr = 1'b1;
                    state_n     = ST_ASSERT;
                end else begin
                    idx_n = idx + IDX_W'(1);
                end
            end
            ST_WAIT: begin
                if (hit || expire) begin
                    if (!hit) ctl.tout = idx_onehot(idx);
                    if (idx == LAST) begin
                        ctl.cnt_clr = 1'b1;
                        state_n     = ST_ASSERT;
                    end else begin
                        idx_n   = idx + IDX_W'(1);
                        state_n = ST_CHECK;
                    end
                end else begin
                    ctl.cnt_inc = 1'b1;
                end
            end
            ST_ASSERT: begin
                if (len_done) begin
                    ctl.rst_end = 1'b1;
                    state_n     = ST_IDLE;
                end else begin
                    ctl.cnt_inc = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || cold) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end
endmodule

// File: rtl/wrs_req_bank.sv
module wrs_req_bank
    import wrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cold,
    input  wrs_ctl_t         ctl,
    input  logic             idle,
    input  logic             stall_en,
    input  logic             stall_clr,
    output logic [N_TGT-1:0] req,
    output logic [N_TGT-1:0] tout,
    output logic             pend
);
    logic clr_ok;
    assign clr_ok = idle && stall_clr && pend;

    for (genvar k = 0; k < N_TGT; k++) begin : g_tgt
        if (k == TGT_TRACE) begin : g_trace
            always_ff @(posedge clk) begin
                if (rst || cold)      req[k] <= 1'b0;
                else if (ctl.rst_end) req[k] <= stall_en;
                else if (ctl.grant[k]) req[k] <= 1'b1;
                else if (clr_ok)      req[k] <= 1'b0;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst || cold)       req[k] <= 1'b0;
                else if (ctl.rst_end)  req[k] <= 1'b0;
                else if (ctl.grant[k]) req[k] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || cold)      tout[k] <= 1'b0;
            else if (ctl.start)   tout[k] <= 1'b0;
            else if (ctl.tout[k]) tout[k] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cold)      pend <= 1'b0;
        else if (ctl.rst_end) pend <= stall_en;
        else if (clr_ok)      pend <= 1'b0;
    end
endmodule

// File: rtl/warm_rst_seq.sv
module warm_rst_seq
    import wrs_pkg::*;
#(
    parameter int TO_W  = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cold_req_i,
    input  logic             sw_warm_req_i,
    input  logic             ext_warm_req_i,
    input  logic [N_TGT-1:0] hs_en_i,
    input  logic [N_TGT-1:0] tgt_in_rst_i,
    input  logic [N_TGT-1:0] hs_ack_i,
    input  logic [TO_W-1:0]  timeout_cyc_i,
    input  logic [LEN_W-1:0] rst_len_i,
    input  logic             stall_clr_i,
    output logic [N_TGT-1:0] hs_req_o,
    output logic             warm_rst_o,
    output logic             stall_pend_o,
    output logic [N_TGT-1:0] hs_timeout_o,
    output logic             busy_o
);
    localparam int CNT_W = (TO_W > LEN_W) ? TO_W : LEN_W;

    wrs_state_e       state;
    wrs_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;

    wrs_fsm #(.TO_W(TO_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cold    (cold_req_i),
        .trig    (sw_warm_req_i || ext_warm_req_i),
        .en      (hs_en_i),
        .inrst   (tgt_in_rst_i),
        .ack     (hs_ack_i),
        .cnt     (cnt),
        .timeout (timeout_cyc_i),
        .rst_len (rst_len_i),
        .state   (state),
        .ctl     (ctl)
    );

    wrs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cold (cold_req_i),
        .clr  (ctl.cnt_clr),
        .inc  (ctl.cnt_inc),
        .cnt  (cnt)
    );

    wrs_req_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cold      (cold_req_i),
        .ctl       (ctl),
        .idle      (state == ST_IDLE),
        .stall_en  (hs_en_i[TGT_TRACE]),
        .stall_clr (stall_clr_i),
        .req       (hs_req_o),
        .tout      (hs_timeout_o),
        .pend      (stall_pend_o)
    );

    assign warm_rst_o = (state == ST_ASSERT);
    assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/wrs_chk.sv
module wrs_chk
    import wrs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cold_req_i,
    input logic             sw_warm_req_i,
    input logic             ext_warm_req_i,
    input logic [N_TGT-1:0] hs_en_i,
    input logic [N_TGT-1:0] tgt_in_rst_i,
    input logic [N_TGT-1:0] hs_req_o,
    input logic             warm_rst_o,
    input logic             stall_pend_o,
    input logic [N_TGT-1:0] hs_timeout_o,
    input logic             busy_o
);
    logic [N_TGT-1:0] prev_req;
    logic [N_TGT-1:0] prev_ok;
    logic [N_TGT-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_req <= '0;
            prev_ok  <= '0;
        end else begin
            prev_req <= hs_req_o;
            prev_ok  <= hs_en_i & ~tgt_in_rst_i;
        end
    end

    assign rise = hs_req_o & ~prev_req;

    p_one_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rise));

    p_rise_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        (rise[3:0] & ~prev_ok[3:0]) == 4'b0);

    p_no_rise_in_warm_r7: assert property (@(posedge clk) disable iff (rst)
        warm_rst_o |-> (rise == '0));

    p_idle_no_warm_r7: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !warm_rst_o);

    p_drop_at_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(warm_rst_o) |-> (hs_req_o[3:0] == 4'b0));

    p_pend_holds_trace_r9: assert property (@(posedge clk) disable iff (rst)
        stall_pend_o |-> hs_req_o[TGT_TRACE]);

    p_cold_abort_r10: assert property (@(posedge clk) disable iff (rst)
        cold_req_i |=> (!busy_o && !warm_rst_o && hs_req_o == '0
                        && !stall_pend_o && hs_timeout_o == '0));

    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (sw_warm_req_i || ext_warm_req_i) && !cold_req_i) |=> busy_o);
endmodule

bind warm_rst_seq wrs_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cold_req_i     (cold_req_i),
    .sw_warm_req_i  (sw_warm_req_i),
    .ext_warm_req_i (ext_warm_req_i),
    .hs_en_i        (hs_en_i),
    .tgt_in_rst_i   (tgt_in_rst_i),
    .hs_req_o       (hs_req_o),
    .warm_rst_o     (warm_rst_o),
    .stall_pend_o   (stall_pend_o),
    .hs_timeout_o   (hs_timeout_o),
    .busy_o         (busy_o)
);

// File: tb/sim_warm_rst_seq.sv
module sim_warm_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cold = 1'b0, sw = 1'b0, ext = 1'b0, clr = 1'b0;
    logic [NT-1:0] en = '0, inrst = '0, ack = '0;
    logic [7:0]    tmo = 8'd6, len = 8'd4;
    logic [NT-1:0] req, tout;
    logic          warm, pend, busy;

    warm_rst_seq u0 (
        .clk(clk), .rst(rst), .cold_req_i(cold), .sw_warm_req_i(sw),
        .ext_warm_req_i(ext), .hs_en_i(en), .tgt_in_rst_i(inrst),
        .hs_ack_i(ack), .timeout_cyc_i(tmo), .rst_len_i(len),
        .stall_clr_i(clr), .hs_req_o(req), .warm_rst_o(warm),
        .stall_pend_o(pend), .hs_timeout_o(tout), .busy_o(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", r, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 deciding, 2 waiting, 3 reset held
    int            m_ph = 0, m_k = 0, m_c = 0;
    logic [NT-1:0] m_req = '0, m_tout = '0;
    logic          m_pend = 1'b0;

    always @(posedge clk) begin
        if (rst || cold) begin
            m_ph = 0; m_k = 0; m_c = 0; m_req = '0; m_tout = '0; m_pend = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (clr && m_pend) begin m_pend = 0; m_req[4] = 0; end
                    if (sw || ext) begin m_tout = '0; m_ph = 1; m_k = 0; end
                end
                1: begin
                    if (en[m_k] && !inrst[m_k]) begin
                        m_req[m_k] = 1; m_c = 0; m_ph = 2;
                    end else if (m_k == 4) begin
                        m_ph = 3; m_c = 0;
                    end else m_k++;
                end
                2: begin
                    if (ack[m_k] || m_c == int'(tmo)) begin
                        if (!ack[m_k]) m_tout[m_k] = 1;
                        if (m_k == 4) begin m_ph = 3; m_c = 0; end
                        else begin m_k++; m_ph = 1; end
                    end else m_c++;
                end
                default: begin
                    if (m_c + 1 >= ((len == 0) ? 1 : int'(len))) begin
                        m_req[3:0] = '0; m_req[4] = en[4]; m_pend = en[4]; m_ph = 0;
                    end else m_c++;
                end
            endcase
        end
    end

    // responder and monitors
    int            dly[NT] = '{2, 2, 2, 2, 2};
    int            age[NT] = '{0, 0, 0, 0, 0};
    int            rise_t[NT] = '{0, 0, 0, 0, 0};
    logic [NT-1:0] ever_req = '0, prev_req = '0;
    int            warm_cyc = 0, warm_pulses = 0;
    logic          prev_warm = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(req == m_req, "R5 req", int'(req), int'(m_req));
            chk(warm == (m_ph == 3), "R7 warm", int'(warm), int'(m_ph == 3));
            chk(pend == m_pend, "R9 pend", int'(pend), int'(m_pend));
            chk(tout == m_tout, "R6 tout", int'(tout), int'(m_tout));
            chk(busy == (m_ph != 0), "R2 busy", int'(busy), int'(m_ph != 0));
        end
        ever_req |= req;
        if (warm) warm_cyc++;
        if (warm && !prev_warm) warm_pulses++;
        prev_warm = warm;
        for (int k = 0; k < NT; k++) begin
            if (req[k] && !prev_req[k]) rise_t[k] = cyc;
            age[k] = req[k] ? age[k] + 1 : 0;
            ack[k] = req[k] && dly[k] >= 0 && age[k] > dly[k];
        end
        prev_req = req;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog R2 actual busy=%0d expected idle", busy);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw = 1; tick(1); sw = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        tick(1);
    endtask

    task automatic fresh();
        ever_req = '0; warm_cyc = 0; warm_pulses = 0;
    endtask

    task automatic release_stall();
        clr = 1; tick(1); clr = 0; tick(1);
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk(req == 0 && tout == 0 && !warm && !pend && !busy, "R1 reset state",
            int'({req, tout, warm, pend, busy}), 0);

        // all enabled, every target acknowledges
        en = 5'b11111; fresh();
        pulse_sw(); wait_idle();
        chk(ever_req == 5'b11111, "R3 all visited", int'(ever_req), 5'h1f);
        chk(rise_t[0] < rise_t[1] && rise_t[1] < rise_t[2] && rise_t[2] < rise_t[3]
            && rise_t[3] < rise_t[4], "R3 ascending order", rise_t[4] - rise_t[0], 1);
        chk(warm_cyc == 4, "R7 reset length", warm_cyc, 4);
        chk(req[3:0] == 0, "R8 requests dropped", int'(req[3:0]), 0);
        chk(pend && req[4], "R9 stall held", int'({pend, req[4]}), 3);
        tick(5);
        chk(pend && req[4], "R9 stall still held", int'({pend, req[4]}), 3);
        release_stall();
        chk(!pend && !req[4], "R9 stall released", int'({pend, req[4]}), 0);

        // subset of targets, external trigger
        en = 5'b01010; fresh();
        ext = 1; tick(1); ext = 0; wait_idle();
        chk(ever_req == 5'b01010, "R3 only enabled", int'(ever_req), 5'h0a);
        chk(!pend, "R9 no stall when disabled", int'(pend), 0);

        // targets already in reset are skipped
        en = 5'b11111; inrst = 5'b00101; fresh();
        pulse_sw(); wait_idle();
        chk(ever_req == 5'b11010, "R4 skip in-reset", int'(ever_req), 5'h1a);
        inrst = '0; release_stall();

        // scan manager never answers
        dly[2] = -1; fresh();
        pulse_sw(); wait_idle();
        chk(tout == 5'b00100, "R6 timeout flag", int'(tout), 5'h04);
        chk(warm_pulses == 1, "R6 sequence continued", warm_pulses, 1);
        dly[2] = 2; release_stall();
        pulse_sw(); tick(1);
        chk(tout == 0, "R6 flags cleared on start", int'(tout), 0);
        wait_idle(); release_stall();

        // second trigger while busy is ignored
        fresh();
        pulse_sw(); tick(3);
        ext = 1; tick(1); ext = 0;
        wait_idle(); tick(10);
        chk(warm_pulses == 1 && !busy, "R2 busy trigger ignored", warm_pulses, 1);
        release_stall();

        // zero length gives one reset cycle
        len = 0; fresh();
        pulse_sw(); wait_idle();
        chk(warm_cyc == 1, "R7 zero length", warm_cyc, 1);
        len = 4; release_stall();

        // cold abort during a wait and during reset
        dly[1] = 20; fresh();
        pulse_sw(); tick(6);
        chk(busy && req != 0, "R5 request held while waiting", int'(req), 3);
        cold = 1; tick(1); cold = 0;
        chk(!busy && req == 0 && !warm && !pend, "R10 abort in wait",
            int'({req, warm, pend, busy}), 0);
        dly[1] = 2; fresh();
        pulse_sw();
        for (int i = 0; i < 5000 && !warm; i++) tick(1);
        cold = 1; tick(1); cold = 0;
        chk(!busy && !warm && req == 0, "R10 abort in reset",
            int'({req, warm, busy}), 0);

        tick(5);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule